// File: doc/BRIEF.md
# Dual Function-Generator Logic Slice

This block holds two 4-input function generators, F and G, each backed by a 16-bit configuration word. A 2-bit mode field picks the behaviour of each generator while the block runs. In lookup mode the word is a truth table indexed by the generator's inputs. In RAM mode the word is a 16x1 memory with a synchronous write and a combinational read. In shift mode the word is a 16-stage shift register, and the generator's inputs choose which stage is read. The same four input bits therefore act as table index, memory address or tap select.

A 2:1 wide multiplexer joins the two generator outputs into one 5-input function, with a separate select pin as the fifth input. Each generator also feeds a storage element. That element can instead take the slice's direct bypass input, and it has a clock enable and a synchronous set/reset to a configured value. For each of the X and Y outputs, configuration chooses the registered value or the combinational generator output.

Configuration words arrive over a valid/ready port as address plus data. The slice never applies back-pressure once reset has been released: `cfg_ready` is low during reset and for the first edge after it, then stays high. A word is taken on every clock edge where valid and ready are both high. The source may hold `cfg_valid` high for several cycles, and each of those cycles is a separate write.

Top module: `lut_slice`

## Requirements
- R1: During reset both generator words and all control fields are zero, so `x_o`, `y_o` and `f5_o` are 0 and `cfg_ready` is 0. `cfg_ready` goes high at the first clock edge after reset is released and then stays high.
- R2: A handshake at address 0 loads the F word, address 1 loads the G word, and address 2 loads the control word from `cfg_data[9:0]`. Address 3 changes nothing. A configuration load of a generator word takes priority over a RAM write or shift of that word in the same cycle.
- R3: In mode 2'b00 and in the reserved mode 2'b11, the generator output equals bit `in` of its word, and `we` leaves the word unchanged.
- R4: In mode 2'b01, an edge with `we` high writes the data bit (`bx` for F, `by` for G) into bit `in` of the word, and the read of bit `in` is combinational.
- R5: In mode 2'b10, an edge with `we` high shifts the word up by one and places the data bit in bit 0. The output is the stage selected by `in`.
- R6: `f5_o` equals the G output when `f5_sel` is 1 and the F output when it is 0.
- R7: On an edge with `ce` high and `sr` low, a storage element loads the generator output, or the bypass input (`bx` for X, `by` for Y) when its bypass bit is set. With `ce` and `sr` both low it holds its value.
- R8: `sr` is synchronous and overrides `ce`. It loads each storage element with its configured set/reset value.
- R9: `x_o` (or `y_o`) shows the storage element when its register bit is set, and otherwise shows the combinational generator output.
- R10: Control word layout: [1:0] F mode, [3:2] G mode, [4] X register select, [5] Y register select, [6] X bypass, [7] Y bypass, [8] X set/reset value, [9] Y set/reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Configuration word offered |
| cfg_ready | output | 1 | Slice accepts configuration |
| cfg_addr | input | 2 | Configuration target: 0 F word, 1 G word, 2 control, 3 unused |
| cfg_data | input | 16 | Configuration data |
| f_in | input | 4 | F generator inputs / address / tap |
| g_in | input | 4 | G generator inputs / address / tap |
| bx | input | 1 | F data-in and X bypass |
| by | input | 1 | G data-in and Y bypass |
| we | input | 1 | RAM write / shift enable for both generators |
| ce | input | 1 | Storage element clock enable |
| sr | input | 1 | Synchronous set/reset of storage elements |
| f5_sel | input | 1 | Wide multiplexer select |
| x_o | output | 1 | X output, registered or combinational |
| y_o | output | 1 | Y output, registered or combinational |
| f5_o | output | 1 | Wide multiplexer output |

## Verification
The hardest case to reach from the ports is a configuration load that lands in the same cycle as a RAM write or shift to the same word, while the generator is in a writable mode. Random stimulus also seldom fills all sixteen shift stages with a known pattern and then reads every tap. Directed sequences therefore set RAM mode and raise `we` together with an F-word load, and they shift a full 16-bit pattern before sweeping `f_in` over every tap. Around these sequences, seeded random traffic mixes configuration writes, including to the unused address, with random modes, enables and set/reset pulses.

// File: rtl/slice_pkg.sv
package slice_pkg;
  typedef enum logic [1:0] {
    MODE_LUT   = 2'b00,
    MODE_RAM   = 2'b01,
    MODE_SHIFT = 2'b10,
    MODE_RSVD  = 2'b11
  } fg_mode_e;

  // Field order fixes the control word layout (f_mode in the low bits).
  typedef struct packed {
    logic     y_srval;
    logic     x_srval;
    logic     y_bypass;
    logic     x_bypass;
    logic     y_reg;
    logic     x_reg;
    fg_mode_e g_mode;
    fg_mode_e f_mode;
  } slice_ctrl_t;

  localparam int CTRL_W = $bits(slice_ctrl_t);
  localparam logic [1:0] CFG_F    = 2'd0;
  localparam logic [1:0] CFG_G    = 2'd1;
  localparam logic [1:0] CFG_CTRL = 2'd2;
endpackage

// File: rtl/slice_fgen.sv
module slice_fgen
  import slice_pkg::*;
#(
  parameter int K = 4,
  localparam int DEPTH = 1 << K
) (
  input  logic             clk,
  input  logic             rst_n,
  input  fg_mode_e         mode,
  input  logic [K-1:0]     sel,
  input  logic             din,
  input  logic             we,
  input  logic             load,
  input  logic [DEPTH-1:0] load_word,
  output logic             out,
  output logic [DEPTH-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
    end else if (load) begin
      word <= load_word;
    end else if (we) begin
      case (mode)
        MODE_RAM:   word[sel] <= din;
        MODE_SHIFT: word <= {word[DEPTH-2:0], din};
        default:    word <= word;
      endcase
    end
  end

  // Table lookup, memory read and tap select share one index path.
  assign out = word[sel];
endmodule

// File: rtl/slice_store.sv
module slice_store (
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  input  logic sr,
  input  logic srval,
  input  logic bypass,
  input  logic gen_d,
  input  logic byp_d,
  output logic q
);
  logic d;
  assign d = bypass ? byp_d : gen_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (sr)  q <= srval;
    else if (ce)  q <= d;
  end
endmodule

// File: rtl/slice_cfg.sv
module slice_cfg
  import slice_pkg::*;
#(
  parameter int K = 4,
  localparam int DEPTH = 1 << K
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_valid,
  input  logic [1:0]       cfg_addr,
  input  logic [DEPTH-1:0] cfg_data,
  output logic             cfg_ready,
  output logic             f_load,
  output logic             g_load,
  output slice_ctrl_t      ctrl
);
  logic take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_ready <= 1'b0;
    else        cfg_ready <= 1'b1;
  end

  assign take   = cfg_valid && cfg_ready;
  assign f_load = take && (cfg_addr == CFG_F);
  assign g_load = take && (cfg_addr == CFG_G);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ctrl <= '0;
    else if (take && cfg_addr == CFG_CTRL)
      ctrl <= slice_ctrl_t'(cfg_data[CTRL_W-1:0]);
  end
endmodule

// File: rtl/lut_slice.sv
module lut_slice
  import slice_pkg::*;
#(
  parameter int K = 4,
  localparam int DEPTH = 1 << K
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_valid,
  output logic             cfg_ready,
  input  logic [1:0]       cfg_addr,
  input  logic [DEPTH-1:0] cfg_data,
  input  logic [K-1:0]     f_in,
  input  logic [K-1:0]     g_in,
  input  logic             bx,
  input  logic             by,
  input  logic             we,
  input  logic             ce,
  input  logic             sr,
  input  logic             f5_sel,
  output logic             x_o,
  output logic             y_o,
  output logic             f5_o
);
  slice_ctrl_t      ctrl;
  logic             f_load, g_load;
  logic [DEPTH-1:0] f_word, g_word;
  logic             xq, yq;

  logic [1:0][K-1:0]     gen_sel;
  logic [1:0]            gen_din, gen_load, gen_out, gen_q;
  logic [1:0]            gen_reg, gen_byp, gen_srval;
  fg_mode_e              gen_mode [2];
  logic [1:0][DEPTH-1:0] gen_word;

  slice_cfg #(.K(K)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .cfg_ready(cfg_ready), .f_load(f_load),
    .g_load(g_load), .ctrl(ctrl)
  );

  assign gen_sel   = {g_in, f_in};
  assign gen_din   = {by, bx};
  assign gen_load  = {g_load, f_load};
  assign gen_reg   = {ctrl.y_reg, ctrl.x_reg};
  assign gen_byp   = {ctrl.y_bypass, ctrl.x_bypass};
  assign gen_srval = {ctrl.y_srval, ctrl.x_srval};
  assign gen_mode[0] = ctrl.f_mode;
  assign gen_mode[1] = ctrl.g_mode;

  for (genvar i = 0; i < 2; i++) begin : g_gen
    slice_fgen #(.K(K)) u_fg (
      .clk(clk), .rst_n(rst_n), .mode(gen_mode[i]), .sel(gen_sel[i]),
      .din(gen_din[i]), .we(we), .load(gen_load[i]), .load_word(cfg_data),
      .out(gen_out[i]), .word(gen_word[i])
    );
    slice_store u_st (
      .clk(clk), .rst_n(rst_n), .ce(ce), .sr(sr), .srval(gen_srval[i]),
      .bypass(gen_byp[i]), .gen_d(gen_out[i]), .byp_d(gen_din[i]),
      .q(gen_q[i])
    );
  end

  assign f_word = gen_word[0];
  assign g_word = gen_word[1];
  assign xq     = gen_q[0];
  assign yq     = gen_q[1];

  assign x_o  = gen_reg[0] ? xq : gen_out[0];
  assign y_o  = gen_reg[1] ? yq : gen_out[1];
  assign f5_o = f5_sel ? gen_out[1] : gen_out[0];
endmodule

// File: rtl/slice_chk.sv
module slice_chk
  import slice_pkg::*;
#(
  parameter int K = 4,
  localparam int DEPTH = 1 << K
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_valid,
  input logic             cfg_ready,
  input logic [1:0]       cfg_addr,
  input logic [K-1:0]     f_in,
  input logic             bx,
  input logic             we,
  input logic             ce,
  input logic             sr,
  input logic [DEPTH-1:0] f_word,
  input logic             xq,
  input slice_ctrl_t      ctrl
);
  logic f_cfg;
  assign f_cfg = cfg_valid && cfg_ready && cfg_addr == CFG_F;

  a_r1_ready_stays: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ready |=> cfg_ready);

  a_r2_unused_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_ready && cfg_addr == 2'd3 && !we) |=> ($stable(f_word) && $stable(ctrl)));

  a_r3_lut_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctrl.f_mode == MODE_LUT || ctrl.f_mode == MODE_RSVD) && !f_cfg) |=> $stable(f_word));

  a_r4_ram_write: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.f_mode == MODE_RAM && we && !f_cfg) |=> (f_word[$past(f_in)] == $past(bx)));

  a_r5_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.f_mode == MODE_SHIFT && we && !f_cfg) |=> (f_word == {$past(f_word[DEPTH-2:0]), $past(bx)}));

  a_r7_ce_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce && !sr) |=> $stable(xq));

  a_r8_sr_wins: assert property (@(posedge clk) disable iff (!rst_n)
    sr |=> (xq == $past(ctrl.x_srval)));
endmodule

bind lut_slice slice_chk #(.K(K)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
  .cfg_addr(cfg_addr), .f_in(f_in), .bx(bx), .we(we), .ce(ce), .sr(sr),
  .f_word(f_word), .xq(xq), .ctrl(ctrl)
);

// File: tb/sim_lut_slice.sv
`timescale 1ns/1ps
module sim_lut_slice;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_valid = 1'b0;
  logic cfg_ready;
  logic [1:0] cfg_addr = '0;
  logic [15:0] cfg_data = '0;
  logic [3:0] f_in = '0, g_in = '0;
  logic bx = 1'b0, by = 1'b0, we = 1'b0, ce = 1'b0, sr = 1'b0, f5_sel = 1'b0;
  logic x_o, y_o, f5_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] fw = '0, gw = '0;
  logic [9:0] ctl = '0;
  logic xq_m = 1'b0, yq_m = 1'b0;

  always #4 clk = ~clk;

  lut_slice u0 (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .f_in(f_in), .g_in(g_in),
    .bx(bx), .by(by), .we(we), .ce(ce), .sr(sr), .f5_sel(f5_sel),
    .x_o(x_o), .y_o(y_o), .f5_o(f5_o)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] nxt(input logic [15:0] w, input logic [1:0] m,
                                      input logic wen, input logic [3:0] a, input logic d);
    logic [15:0] r = w;
    if (wen && m == 2'b01) r[a] = d;
    if (wen && m == 2'b10) r = {w[14:0], d};
    return r;
  endfunction

  function automatic string mtag(input logic [1:0] m);
    return (m == 2'b01) ? "R4" : (m == 2'b10) ? "R5" : "R3";
  endfunction

  // Inputs are set just after a falling edge; compare, then advance the model.
  task automatic cycle();
    logic fo, go, take;
    #1;
    fo = fw[f_in];
    go = gw[g_in];
    check("R2 ready", cfg_ready, 1'b1);
    check(ctl[4] ? "R9 R7 R8 x" : {mtag(ctl[1:0]), " R9 x"}, x_o, ctl[4] ? xq_m : fo);
    check(ctl[5] ? "R9 R7 R8 y" : {mtag(ctl[3:2]), " R9 y"}, y_o, ctl[5] ? yq_m : go);
    check("R6 f5", f5_o, f5_sel ? go : fo);
    @(posedge clk);
    take = cfg_valid;
    if (sr) begin
      xq_m = ctl[8]; yq_m = ctl[9];
    end else if (ce) begin
      xq_m = ctl[6] ? bx : fo;
      yq_m = ctl[7] ? by : go;
    end
    fw = (take && cfg_addr == 2'd0) ? cfg_data : nxt(fw, ctl[1:0], we, f_in, bx);
    gw = (take && cfg_addr == 2'd1) ? cfg_data : nxt(gw, ctl[3:2], we, g_in, by);
    if (take && cfg_addr == 2'd2) ctl = cfg_data[9:0];
    @(negedge clk);
  endtask

  task automatic idle();
    cfg_valid = 0; we = 0; ce = 0; sr = 0;
  endtask

  task automatic cfg(input logic [1:0] a, input logic [15:0] d);
    idle();
    cfg_valid = 1; cfg_addr = a; cfg_data = d;
    cycle();
    cfg_valid = 0;
  endtask

  initial begin
    #1_600_000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 x_o in reset", x_o, 1'b0);
    check("R1 y_o in reset", y_o, 1'b0);
    check("R1 f5_o in reset", f5_o, 1'b0);
    check("R1 cfg_ready in reset", cfg_ready, 1'b0);
    rst_n = 1;
    @(negedge clk);
    check("R1 cfg_ready after reset", cfg_ready, 1'b1);

    // R3 reserved mode: we must not alter the table
    cfg(2'd0, 16'hA5C3);
    cfg(2'd2, 10'b00_00_00_00_11);
    for (int i = 0; i < 16; i++) begin
      idle(); we = 1; bx = ~fw[i]; f_in = 4'(i); f5_sel = 0;
      cycle();
    end
    check("R3 reserved mode word kept", fw == 16'hA5C3, 1'b1);

    // R5 full shift then sweep every tap
    cfg(2'd2, 10'b00_00_00_00_10);
    for (int i = 0; i < 16; i++) begin
      idle(); we = 1; bx = 1'((16'h6D29 >> (15 - i)) & 1); f_in = 4'(i);
      cycle();
    end
    for (int i = 0; i < 16; i++) begin
      idle(); f_in = 4'(i); cycle();
      check("R5 tap after 16 shifts", fw[i], 1'((16'h6D29 >> i) & 1));
    end

    // R2 config load beats a RAM write in the same cycle
    cfg(2'd2, 10'b00_00_00_00_01);
    idle(); cfg_valid = 1; cfg_addr = 2'd0; cfg_data = 16'h0F0F; we = 1; bx = 1; f_in = 4'd0;
    cycle();
    idle(); f_in = 4'd0; cycle();
    // R2 unused address leaves state alone
    idle(); cfg_valid = 1; cfg_addr = 2'd3; cfg_data = 16'hFFFF; cycle();
    check("R2 addr3 ignored", fw == 16'h0F0F && ctl[1:0] == 2'b01, 1'b1);

    // R8 sr overrides ce; R7 bypass; R9 registered view; R10 layout
    cfg(2'd2, 10'b10_11_11_01_01);
    idle(); sr = 1; ce = 1; bx = 0; by = 1; cycle();
    idle(); cycle();
    idle(); ce = 1; bx = 1; by = 0; cycle();
    idle(); cycle();

    // seeded random traffic
    for (int n = 0; n < 4000; n++) begin
      idle();
      cfg_valid = ($urandom % 8) == 0;
      cfg_addr  = 2'($urandom);
      cfg_data  = 16'($urandom);
      f_in = 4'($urandom); g_in = 4'($urandom);
      bx = 1'($urandom); by = 1'($urandom);
      we = 1'($urandom); ce = 1'($urandom);
      sr = ($urandom % 16) == 0;
      f5_sel = 1'($urandom);
      cycle();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule